// File: doc/BRIEF.md
# Round-Robin Window Comparator Sequencer

The block scans a programmable list of input channels over and over, one channel after another. Each channel has a 10-bit low limit and a 10-bit high limit. The block checks one sample per visited channel against that window. A sample outside the window sets a sticky status bit for that channel, and the status bits, masked by per-channel enables, form one interrupt line.

The input pins are shared with a main converter. Before the block drives the channel selection it raises a request to a shared-pin arbiter and waits for a grant. It takes one sample and then releases the request for a cycle, so the arbiter can slot converter accesses in between. Two operating modes each carry their own scan list and list length. Software picks the mode, and a change of mode waits until the current scan has ended. All configuration is written through a simple write-only register port.

Top module: `rr_window_seq`

## Requirements
- R1: A 10-bit sample accepted for channel c is a violation when it is strictly greater than high[c] or strictly less than low[c]. A sample equal to either limit is not a violation.
- R2: Scan positions run 0, 1, …, L-1 and then back to 0, advancing by one on each accepted sample. L is the list length of the active mode.
- R3: Each of the two modes has its own list of 14 entries, and each entry holds a 4-bit channel index. A write to the mode register takes effect only after the sample at the last position, and the scan then restarts at position 0 in the new mode.
- R4: A violation on channel c sets status bit c, and the bit is visible in the cycle after the sample is accepted.
- R5: Status bits are sticky. Writing ones to the clear register clears those bits. If a clear and a new violation hit the same bit in the same cycle, the bit stays set.
- R6: The request is raised before any selection. sel_en goes high only in the cycle after one where both request and grant were high, and it is low while the grant is withheld. ch_sel reads 0 whenever sel_en is low.
- R7: After every accepted sample, the request is low for exactly one cycle and then rises again.
- R8: irq is the OR, over all channels, of each status bit ANDed with its enable bit.
- R9: A written list length is clamped to the range 5..14.
- R10: After reset: status is 0, irq is 0, request is high, sel_en is 0, every low limit is 0, every high limit is 1023, list entry p of both modes is channel p, both lengths are 14, mode 0 is active and all enables are 0.
- R11: smp_valid is ignored unless sel_en is high.
- R12: Register addresses:
  - 0x00+c holds the low limit of channel c (data bits 9:0).
  - 0x10+c holds the high limit of channel c.
  - 0x20+16m+p holds list entry p of mode m (bits 3:0, p<14).
  - 0x40+m holds the length of mode m.
  - 0x42 is the mode select (bit 0).
  - 0x43 holds the interrupt enables (bits 15:0).
  - 0x44 is the status clear (bits 15:0, write one to clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Register write data |
| arb_req | output | 1 | Request to the shared-pin arbiter |
| arb_gnt | input | 1 | Grant from the arbiter, held while the request is high |
| sel_en | output | 1 | Channel selection driven |
| ch_sel | output | 4 | Selected channel index |
| smp_valid | input | 1 | Sample valid for the selected channel |
| smp_data | input | 10 | Sample value |
| status | output | 16 | Sticky violation bits, one per channel |
| irq | output | 1 | Interrupt |

## Verification
A status clear write and a new violation on the same channel can land in the same cycle. To provoke this, every window is set to 1023..1023, so nearly any sample violates. The bench then writes an all-ones clear on every cycle for a long stretch, which makes each accepted sample coincide with a clear. A cycle-accurate behavioural model predicts the result, and after each such coincidence the bench confirms that the channel's bit is still set. The bench also counts the coincidences, so a run that never produced one is reported.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
    typedef enum logic [1:0] {
        SC_REQ  = 2'd0,
        SC_HOLD = 2'd1,
        SC_REL  = 2'd2
    } scan_st_e;
endpackage

// File: rtl/rrw_regs.sv
module rrw_regs #(
    parameter int NUM_CH    = 16,
    parameter int DW        = 10,
    parameter int NUM_MODES = 2,
    parameter int MIN_LEN   = 5,
    parameter int MAX_LEN   = 14,
    parameter int ADDR_W    = 7,
    parameter int WD_W      = 16,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
    localparam int POS_W    = $clog2(MAX_LEN),
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WD_W-1:0]   wdata_i,
    input  logic [MODE_W-1:0] lk_mode_i,
    input  logic [POS_W-1:0]  lk_pos_i,
    output logic [CH_W-1:0]   lk_ch_o,
    output logic [DW-1:0]     lo_o,
    output logic [DW-1:0]     hi_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [MODE_W-1:0] mode_req_o,
    output logic [NUM_CH-1:0] ien_o,
    output logic [NUM_CH-1:0] clr_o
);
    localparam int LO_BASE   = 0;
    localparam int HI_BASE   = NUM_CH;
    localparam int LIST_BASE = 2 * NUM_CH;
    localparam int LEN_BASE  = LIST_BASE + NUM_MODES * NUM_CH;
    localparam int MODE_ADDR = LEN_BASE + NUM_MODES;
    localparam int IEN_ADDR  = MODE_ADDR + 1;
    localparam int CLR_ADDR  = MODE_ADDR + 2;

    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0]                   lo;
        logic [NUM_CH-1:0][DW-1:0]                   hi;
        logic [NUM_MODES-1:0][MAX_LEN-1:0][CH_W-1:0] lst;
        logic [NUM_MODES-1:0][LEN_W-1:0]             len;
        logic [MODE_W-1:0]                           mode;
        logic [NUM_CH-1:0]                           ien;
    } regs_t;

    regs_t r_d, r_q;

    function automatic regs_t reg_reset();
        regs_t v;
        v = '0;
        for (int c = 0; c < NUM_CH; c++) v.hi[c] = '1;
        for (int m = 0; m < NUM_MODES; m++) begin
            v.len[m] = LEN_W'(MAX_LEN);
            for (int p = 0; p < MAX_LEN; p++) v.lst[m][p] = CH_W'(p % NUM_CH);
        end
        return v;
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [WD_W-1:0] v);
        if (v < WD_W'(MIN_LEN)) return LEN_W'(MIN_LEN);
        if (v > WD_W'(MAX_LEN)) return LEN_W'(MAX_LEN);
        return v[LEN_W-1:0];
    endfunction

    always_comb begin
        r_d   = r_q;
        clr_o = '0;
        if (we_i) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr_i == ADDR_W'(LO_BASE + c)) r_d.lo[c] = wdata_i[DW-1:0];
                if (addr_i == ADDR_W'(HI_BASE + c)) r_d.hi[c] = wdata_i[DW-1:0];
            end
            for (int m = 0; m < NUM_MODES; m++) begin
                for (int p = 0; p < MAX_LEN; p++) begin
                    if (addr_i == ADDR_W'(LIST_BASE + m * NUM_CH + p))
                        r_d.lst[m][p] = wdata_i[CH_W-1:0];
                end
                if (addr_i == ADDR_W'(LEN_BASE + m)) r_d.len[m] = clamp_len(wdata_i);
            end
            if (addr_i == ADDR_W'(MODE_ADDR) && int'(wdata_i[MODE_W-1:0]) < NUM_MODES)
                r_d.mode = wdata_i[MODE_W-1:0];
            if (addr_i == ADDR_W'(IEN_ADDR)) r_d.ien = wdata_i[NUM_CH-1:0];
            if (addr_i == ADDR_W'(CLR_ADDR)) clr_o = wdata_i[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= reg_reset();
        else        r_q <= r_d;
    end

    assign lk_ch_o    = r_q.lst[lk_mode_i][lk_pos_i];
    assign lo_o       = r_q.lo[lk_ch_o];
    assign hi_o       = r_q.hi[lk_ch_o];
    assign len_o      = r_q.len[lk_mode_i];
    assign mode_req_o = r_q.mode;
    assign ien_o      = r_q.ien;

    // R9: whatever was written, every stored length sits inside the window
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_len_chk
        a_r9_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && addr_i == ADDR_W'(LEN_BASE + m)) |=>
            (r_q.len[m] >= LEN_W'(MIN_LEN) && r_q.len[m] <= LEN_W'(MAX_LEN)));
    end
endmodule

// File: rtl/rrw_scan.sv
module rrw_scan
    import rrw_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_MODES = 2,
    parameter int MAX_LEN   = 14,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
    localparam int POS_W    = $clog2(MAX_LEN),
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_i,
    input  logic              valid_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [MODE_W-1:0] mode_req_i,
    input  logic [CH_W-1:0]   lk_ch_i,
    output logic              req_o,
    output logic              sel_en_o,
    output logic [CH_W-1:0]   ch_o,
    output logic              acc_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [POS_W-1:0]  pos_o
);
    typedef struct packed {
        scan_st_e          st;
        logic [POS_W-1:0]  pos;
        logic [MODE_W-1:0] mode;
    } scan_t;

    scan_t s_d, s_q;
    logic  last_pos;

    assign last_pos = (LEN_W'(s_q.pos) + LEN_W'(1)) >= len_i;

    always_comb begin
        s_d   = s_q;
        acc_o = (s_q.st == SC_HOLD) && valid_i;
        case (s_q.st)
            SC_REQ:  if (gnt_i) s_d.st = SC_HOLD;
            SC_HOLD: if (valid_i) begin
                s_d.st = SC_REL;
                if (last_pos) begin
                    s_d.pos  = '0;
                    s_d.mode = mode_req_i;
                end else begin
                    s_d.pos = s_q.pos + POS_W'(1);
                end
            end
            default: s_d.st = SC_REQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SC_REQ, pos: '0, mode: '0};
        else        s_q <= s_d;
    end

    assign req_o    = (s_q.st != SC_REL);
    assign sel_en_o = (s_q.st == SC_HOLD);
    assign ch_o     = sel_en_o ? lk_ch_i : '0;
    assign mode_o   = s_q.mode;
    assign pos_o    = s_q.pos;

    a_r6_sel_granted: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en_o |-> gnt_i);
    a_r7_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |=> (!req_o ##1 req_o));
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && last_pos) |=> (s_q.pos == '0));
    a_r3_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_o && last_pos) |=> $stable(s_q.mode));
endmodule

// File: rtl/rrw_judge.sv
module rrw_judge #(
    parameter int NUM_CH = 16,
    parameter int DW     = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [DW-1:0]     sample_i,
    input  logic [DW-1:0]     lo_i,
    input  logic [DW-1:0]     hi_i,
    input  logic [NUM_CH-1:0] clr_i,
    input  logic [NUM_CH-1:0] ien_i,
    output logic [NUM_CH-1:0] status_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] stat;
    } judge_t;

    judge_t j_d, j_q;
    logic   outside;
    logic [NUM_CH-1:0] hit;

    always_comb begin
        outside     = (sample_i > hi_i) || (sample_i < lo_i);
        hit         = '0;
        hit[ch_i]   = acc_i && outside;
        j_d.stat    = (j_q.stat & ~clr_i) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) j_q <= '0;
        else        j_q <= j_d;
    end

    assign status_o = j_q.stat;
    assign irq_o    = |(j_q.stat & ien_i);

    a_r4_above_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && sample_i > hi_i) |=> status_o[$past(ch_i)]);
    a_r4_below_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && sample_i < lo_i) |=> status_o[$past(ch_i)]);
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((status_o & $past(status_o)) == $past(status_o)));
    a_r1_inside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && sample_i >= lo_i && sample_i <= hi_i && clr_i == '0) |=> $stable(status_o));
endmodule

// File: rtl/rr_window_seq.sv
module rr_window_seq #(
    parameter int NUM_CH    = 16,
    parameter int DW        = 10,
    parameter int NUM_MODES = 2,
    parameter int MIN_LEN   = 5,
    parameter int MAX_LEN   = 14,
    parameter int ADDR_W    = 7,
    parameter int WD_W      = 16,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
    localparam int POS_W    = $clog2(MAX_LEN),
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WD_W-1:0]   reg_wdata,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              sel_en,
    output logic [CH_W-1:0]   ch_sel,
    input  logic              smp_valid,
    input  logic [DW-1:0]     smp_data,
    output logic [NUM_CH-1:0] status,
    output logic              irq
);
    logic [MODE_W-1:0] act_mode, mode_req;
    logic [POS_W-1:0]  pos;
    logic [CH_W-1:0]   cur_ch;
    logic [DW-1:0]     lo_lim, hi_lim;
    logic [LEN_W-1:0]  cur_len;
    logic [NUM_CH-1:0] ien, clr;
    logic              acc;

    rrw_regs #(
        .NUM_CH(NUM_CH), .DW(DW), .NUM_MODES(NUM_MODES), .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W), .WD_W(WD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
        .lk_mode_i(act_mode), .lk_pos_i(pos), .lk_ch_o(cur_ch), .lo_o(lo_lim), .hi_o(hi_lim),
        .len_o(cur_len), .mode_req_o(mode_req), .ien_o(ien), .clr_o(clr)
    );

    rrw_scan #(
        .NUM_CH(NUM_CH), .NUM_MODES(NUM_MODES), .MAX_LEN(MAX_LEN)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .gnt_i(arb_gnt), .valid_i(smp_valid), .len_i(cur_len),
        .mode_req_i(mode_req), .lk_ch_i(cur_ch), .req_o(arb_req), .sel_en_o(sel_en),
        .ch_o(ch_sel), .acc_o(acc), .mode_o(act_mode), .pos_o(pos)
    );

    rrw_judge #(
        .NUM_CH(NUM_CH), .DW(DW)
    ) u_judge (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .ch_i(cur_ch), .sample_i(smp_data),
        .lo_i(lo_lim), .hi_i(hi_lim), .clr_i(clr), .ien_i(ien), .status_o(status), .irq_o(irq)
    );
endmodule

// File: tb/rr_window_seq_tb.sv
module rr_window_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        arb_gnt = 1'b0;
    logic        smp_valid = 1'b0;
    logic [9:0]  smp_data = '0;
    logic        arb_req, sel_en, irq;
    logic [3:0]  ch_sel;
    logic [15:0] status;

    int nchk = 0, nerr = 0, cyc = 0;
    int data_mode = 0, coll_cnt = 0;
    bit block_gnt = 1'b0, coll_pend = 1'b0;
    int coll_ch = 0;

    // behavioural reference state
    int m_lo[16], m_hi[16], m_lst[2][14], m_len[2];
    int m_st, m_pos, m_mact, m_mreq;
    logic [15:0] m_stat, m_ien;

    always #10 clk = ~clk;

    rr_window_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .arb_req(arb_req), .arb_gnt(arb_gnt), .sel_en(sel_en), .ch_sel(ch_sel),
        .smp_valid(smp_valid), .smp_data(smp_data), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int pick();
        case (data_mode)
            2: return ($urandom % 2) ? 300 : 700;
            3: return ($urandom % 2) ? 299 : 701;
            4: return $urandom % 1023;
            default: return $urandom % 1024;
        endcase
    endfunction

    // reference model: one step per rising edge, from the inputs present at that edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int c = 0; c < 16; c++) begin m_lo[c] = 0; m_hi[c] = 1023; end
            for (int m = 0; m < 2; m++) begin
                m_len[m] = 14;
                for (int p = 0; p < 14; p++) m_lst[m][p] = p;
            end
            m_st = 0; m_pos = 0; m_mact = 0; m_mreq = 0; m_stat = '0; m_ien = '0;
        end else begin
            bit acc, viol;
            int ch, a;
            logic [15:0] clr;
            acc  = (m_st == 1) && smp_valid;
            ch   = m_lst[m_mact][m_pos];
            viol = acc && (int'(smp_data) > m_hi[ch] || int'(smp_data) < m_lo[ch]);
            clr  = (reg_we && reg_addr == 7'h44) ? reg_wdata : 16'h0;
            if (viol && clr[ch]) begin coll_cnt++; coll_pend = 1'b1; coll_ch = ch; end
            m_stat = (m_stat & ~clr) | (viol ? (16'h1 << ch) : 16'h0);
            if (acc) begin
                if (m_pos + 1 >= m_len[m_mact]) begin m_pos = 0; m_mact = m_mreq; end
                else m_pos++;
            end
            case (m_st)
                0: if (arb_gnt) m_st = 1;
                1: if (smp_valid) m_st = 2;
                default: m_st = 0;
            endcase
            if (reg_we) begin
                a = int'(reg_addr);
                if (a < 16) m_lo[a] = int'(reg_wdata[9:0]);
                else if (a < 32) m_hi[a-16] = int'(reg_wdata[9:0]);
                else if (a < 64) begin
                    if ((a - 32) % 16 < 14) m_lst[(a-32)/16][(a-32)%16] = int'(reg_wdata[3:0]);
                end
                else if (a == 64 || a == 65)
                    m_len[a-64] = (reg_wdata < 5) ? 5 : (reg_wdata > 14) ? 14 : int'(reg_wdata);
                else if (a == 66) m_mreq = int'(reg_wdata[0]);
                else if (a == 67) m_ien = reg_wdata;
            end
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_ch;
            exp_ch = (m_st == 1) ? m_lst[m_mact][m_pos] : 0;
            chk(arb_req === (m_st != 2), "R6 R7", "arb_req", int'(arb_req), int'(m_st != 2));
            chk(sel_en === (m_st == 1), "R6 R11", "sel_en", int'(sel_en), int'(m_st == 1));
            chk(int'(ch_sel) == exp_ch, "R2 R3 R9 R12", "ch_sel", int'(ch_sel), exp_ch);
            chk(status === m_stat, "R1 R4 R5 R11", "status", int'(status), int'(m_stat));
            chk(irq === (|(m_stat & m_ien)), "R8", "irq", int'(irq), int'(|(m_stat & m_ien)));
            if (coll_pend) begin
                chk(status[coll_ch] === 1'b1, "R5", "set-beats-clear bit", int'(status[coll_ch]), 1);
                coll_pend = 1'b0;
            end
        end
    end

    // shared-pin arbiter: grant held while requested, new grants can be withheld
    always @(negedge clk)
        arb_gnt <= arb_req && (arb_gnt || (!block_gnt && ($urandom % 4 != 0)));

    // converter side: samples for the selected channel, stray strobes otherwise
    always @(negedge clk) begin
        if (sel_en) smp_valid <= ($urandom % 3 == 0);
        else        smp_valid <= ($urandom % 8 == 0);
        smp_data <= 10'(pick());
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we <= 1'b1; reg_addr <= 7'(a); reg_wdata <= 16'(d);
        @(negedge clk);
        reg_we <= 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                nchk++; nerr++;
                $display("FAIL watchdog expired actual=%0d expected=0", cyc);
                $display("CHECKS %0d ERRORS %0d", nchk, nerr);
                $finish;
            end
        join_none

        // R10: reset state
        repeat (4) @(negedge clk);
        chk(arb_req === 1'b1 && sel_en === 1'b0, "R10", "req/sel in reset", int'({arb_req, sel_en}), 2);
        chk(status === 16'h0 && irq === 1'b0, "R10", "status/irq in reset", int'(status), 0);
        rst_n <= 1'b1;

        // default window 0..1023 never trips
        idle(200);
        chk(status === 16'h0, "R10 R1", "status with reset limits", int'(status), 0);

        // per-channel windows, partial interrupt enable
        for (int c = 0; c < 16; c++) begin
            wr(c, 100 + c * 10);
            wr(16 + c, 800 - c * 20);
        end
        wr(67, 16'h00F3);
        idle(400);

        // R1 boundaries: equal to the limit is inside
        for (int c = 0; c < 16; c++) begin wr(c, 300); wr(16 + c, 700); end
        wr(68, 16'hFFFF);
        data_mode = 2;
        idle(300);
        chk(status === 16'h0, "R1", "samples equal to limits", int'(status), 0);
        data_mode = 3;
        idle(300);
        chk(status !== 16'h0, "R1", "samples one past limits", int'(status), 1);

        // R3 R9: separate list for mode 1, clamped lengths, mode switch at boundary
        for (int p = 0; p < 14; p++) wr(48 + p, (p * 3 + 1) % 16);
        wr(65, 2);
        wr(64, 40);
        wr(66, 1);
        data_mode = 0;
        idle(300);
        wr(64, 7);
        wr(66, 0);
        idle(300);

        // R5 collision: every sample violates while a full clear is written each cycle
        for (int c = 0; c < 16; c++) begin wr(c, 1023); wr(16 + c, 1023); end
        data_mode = 4;
        @(negedge clk);
        reg_we <= 1'b1; reg_addr <= 7'h44; reg_wdata <= 16'hFFFF;
        idle(300);
        reg_we <= 1'b0;
        chk(coll_cnt > 0, "R5", "clear/violation coincidences seen", coll_cnt, 1);
        idle(20);

        // R6 R11: grants withheld, stray strobes carry violating data
        block_gnt = 1'b1;
        idle(30);
        wr(68, 16'hFFFF);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(sel_en === 1'b0 && ch_sel === 4'h0, "R6", "selection while grant withheld", int'(sel_en), 0);
            chk(status === 16'h0, "R11", "stray strobe ignored", int'(status), 0);
        end
        block_gnt = 1'b0;
        idle(200);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule